// File: doc/BRIEF.md
# Atomic Signed-Maximum Memory Unit

This unit carries out one indivisible read-modify-write on a single memory location. A request supplies a register operand, a base address with the index of the register it came from, a destination register index, an access-size bit and two ordering flags. The unit reads the addressed location, compares the stored value with the register operand as two's-complement numbers at the selected width, and writes the larger one back. The memory is held locked for the whole read-then-write pair, so no other requester can reach it in between.

The value that memory held before the update is returned on a response channel for register writeback, together with a write enable that is cleared when the destination is the discard index (31). Base index 31 names the stack pointer. Its address must be 16-byte aligned, and a misaligned one ends the request with a fault and no memory traffic. During the locked sequence the unit drives acquire, release and tag-check attributes that it derives from the flags and the register indices.

The request and response ports are valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Once `resp_valid` rises, it and every response field stay constant until a cycle with `resp_ready` high. The memory port holds `mem_valid` and all its fields until a cycle with `mem_ready` high. On a read, data is sampled from `mem_rdata` in that same cycle.

Top module: `amax_unit`

## Requirements
- R1: `req_ready` is high only when the unit is idle (no memory access and no pending response). A request is accepted only on a cycle where `req_valid` and `req_ready` are both high.
- R2: A request that does not fault makes exactly one read and then exactly one write, both to the request address. `mem_we`=0 marks the read and `mem_we`=1 marks the write. `mem_lock` is high from the read request through the write acknowledge and falls right after it. The write happens even when the stored value is already the larger.
- R3: The write data is the signed maximum of the stored value and the register operand. With `req_wide`=1 the comparison uses all 64 bits. With `req_wide`=0 it uses bits [31:0] only, and bits [63:32] of the write data are zero.
- R4: `resp_data` is the value read before the update. With `req_wide`=0 it is bits [31:0] of the read data, zero-extended to 64 bits.
- R5: `resp_wb_en` is 0 when the destination index is 31, and 1 otherwise (on a request that does not fault). `resp_idx` returns the destination index.
- R6: While `mem_lock` is high, `ord_acquire` equals the acquire flag ANDed with (destination index != 31), and `ord_release` equals the release flag. Both are 0 while `mem_lock` is low.
- R7: With base index 31, any nonzero address bit [3:0] gives a response with `resp_fault`=1, `resp_wb_en`=0 and `resp_data`=0, and no memory access is made. With any other base index no alignment check is made.
- R8: While `mem_lock` is high, `ord_tag_chk` is 1 exactly when the base index is not 31.
- R9: If memory acknowledges at once, `resp_valid` rises exactly two clock edges after the accepting edge for every non-faulting request, whatever the operand values.
- R10: While a response waits for `resp_ready`, `resp_valid` and `resp_data` stay constant. While a memory access waits for `mem_ready`, `mem_valid`, `mem_we` and `mem_addr` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (high when idle) |
| req_wide | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| req_acq | input | 1 | Acquire flag |
| req_rel | input | 1 | Release flag |
| req_operand | input | 64 | Register operand |
| req_base_addr | input | 64 | Base address |
| req_base_idx | input | 5 | Base register index (31 = stack pointer) |
| req_dst_idx | input | 5 | Destination register index (31 = discard) |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | Access width, 1 = 64-bit |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, sampled when `mem_ready` is high on a read |
| mem_lock | output | 1 | Memory held exclusive for this unit |
| ord_acquire | output | 1 | Acquire attribute of the locked access |
| ord_release | output | 1 | Release attribute of the locked access |
| ord_tag_chk | output | 1 | Tag-check attribute of the locked access |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response ready |
| resp_fault | output | 1 | Alignment fault |
| resp_wb_en | output | 1 | Register writeback enable |
| resp_idx | output | 5 | Destination register index |
| resp_data | output | 64 | Pre-update memory value |

## Verification
Each size is exercised with the following operand pairs:
- Register larger and memory larger, which shows the unit picks the maximum rather than a fixed side.
- Operands of mixed sign and the extreme values 0x8000... against 0x7FFF..., which separate a signed compare from an unsigned one.
- In 32-bit mode, operands with nonzero high halves, which show that the high halves neither affect the compare nor leak into the write data or the response.

The destination, base and flag values are varied across these runs so that every combination of writeback suppression, acquire masking and tag checking appears. Further runs cover:
- A misaligned stack-pointer address, to show the fault path issues no access.
- The same misaligned address with an ordinary base index, to show the fault path is taken only for index 31.
- Memory stalls and response back-pressure.

// File: rtl/amax_pkg.sv
package amax_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } amax_state_e;

  typedef struct packed {
    logic acquire;
    logic release_;
    logic tag_chk;
    logic wb_en;
    logic misaligned;
  } amax_attr_t;

endpackage

// File: rtl/amax_decode.sv
module amax_decode
  import amax_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 4
) (
  input  logic              acq_i,
  input  logic              rel_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output amax_attr_t        attr_o
);
  localparam logic [IDX_W-1:0] SPECIAL_IDX = '1;

  logic base_is_sp;
  logic dst_discard;

  assign base_is_sp  = (base_idx_i == SPECIAL_IDX);
  assign dst_discard = (dst_idx_i == SPECIAL_IDX);

  always_comb begin
    attr_o            = '0;
    attr_o.acquire    = acq_i & ~dst_discard;
    attr_o.release_   = rel_i;
    attr_o.tag_chk    = ~base_is_sp;
    attr_o.wb_en      = ~dst_discard;
    attr_o.misaligned = base_is_sp & (|addr_i[ALIGN_BITS-1:0]);
  end
endmodule

// File: rtl/amax_smax.sv
module amax_smax #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              wide_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [DATA_W-1:0] reg_val_i,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] ret_o
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] wide_max;
  assign wide_max = ($signed(mem_val_i) > $signed(reg_val_i)) ? mem_val_i : reg_val_i;

  generate
    if (PAD_W > 0) begin : g_narrow
      logic [NARROW_W-1:0] lo_mem, lo_reg, lo_max;
      assign lo_mem = mem_val_i[NARROW_W-1:0];
      assign lo_reg = reg_val_i[NARROW_W-1:0];
      assign lo_max = ($signed(lo_mem) > $signed(lo_reg)) ? lo_mem : lo_reg;
      assign max_o  = wide_i ? wide_max  : {{PAD_W{1'b0}}, lo_max};
      assign ret_o  = wide_i ? mem_val_i : {{PAD_W{1'b0}}, lo_mem};
    end else begin : g_wide_only
      logic unused_wide;
      assign unused_wide = wide_i;
      assign max_o = wide_max;
      assign ret_o = mem_val_i;
    end
  endgenerate
endmodule

// File: rtl/amax_ctrl.sv
module amax_ctrl
  import amax_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  logic        misaligned_i,
  input  logic        mem_ready_i,
  input  logic        resp_ready_i,
  output amax_state_e state_o
);
  amax_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_i)     state_d = misaligned_i ? ST_DONE : ST_READ;
      ST_READ:  if (mem_ready_i)  state_d = ST_WRITE;
      ST_WRITE: if (mem_ready_i)  state_d = ST_DONE;
      ST_DONE:  if (resp_ready_i) state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/amax_unit.sv
module amax_unit
  import amax_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int NARROW_W   = 32,
  parameter int ADDR_W     = 64,
  parameter int IDX_W      = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wide,
  input  logic              req_acq,
  input  logic              req_rel,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [ADDR_W-1:0] req_base_addr,
  input  logic [IDX_W-1:0]  req_base_idx,
  input  logic [IDX_W-1:0]  req_dst_idx,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_lock,
  output logic              ord_acquire,
  output logic              ord_release,
  output logic              ord_tag_chk,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_fault,
  output logic              resp_wb_en,
  output logic [IDX_W-1:0]  resp_idx,
  output logic [DATA_W-1:0] resp_data
);
  amax_state_e       state;
  amax_attr_t        attr_d, attr_q;
  logic              accept;
  logic              wide_q, fault_q;
  logic [DATA_W-1:0] opnd_q, rdata_q, max_val, ret_val;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  dst_q;

  amax_decode #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_decode (
    .acq_i      (req_acq),
    .rel_i      (req_rel),
    .base_idx_i (req_base_idx),
    .dst_idx_i  (req_dst_idx),
    .addr_i     (req_base_addr),
    .attr_o     (attr_d)
  );

  amax_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .misaligned_i (attr_d.misaligned),
    .mem_ready_i  (mem_ready),
    .resp_ready_i (resp_ready),
    .state_o      (state)
  );

  amax_smax #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_smax (
    .wide_i    (wide_q),
    .mem_val_i (rdata_q),
    .reg_val_i (opnd_q),
    .max_o     (max_val),
    .ret_o     (ret_val)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attr_q  <= '0;
      wide_q  <= 1'b0;
      fault_q <= 1'b0;
      opnd_q  <= '0;
      addr_q  <= '0;
      dst_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        attr_q  <= attr_d;
        wide_q  <= req_wide;
        fault_q <= attr_d.misaligned;
        opnd_q  <= req_operand;
        addr_q  <= req_base_addr;
        dst_q   <= req_dst_idx;
        rdata_q <= '0;
      end else if (state == ST_READ && mem_ready) begin
        rdata_q <= mem_rdata;
      end
    end
  end

  assign mem_valid   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we      = (state == ST_WRITE);
  assign mem_wide    = wide_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = mem_we ? max_val : '0;
  assign mem_lock    = mem_valid;
  assign ord_acquire = mem_lock & attr_q.acquire;
  assign ord_release = mem_lock & attr_q.release_;
  assign ord_tag_chk = mem_lock & attr_q.tag_chk;

  assign resp_valid  = (state == ST_DONE);
  assign resp_fault  = fault_q;
  assign resp_wb_en  = attr_q.wb_en & ~fault_q;
  assign resp_idx    = dst_q;
  assign resp_data   = fault_q ? '0 : ret_val;
endmodule

// File: rtl/amax_unit_chk.sv
module amax_unit_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_lock,
  input logic              ord_acquire,
  input logic              ord_release,
  input logic              ord_tag_chk,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_fault,
  input logic              resp_wb_en,
  input logic [IDX_W-1:0]  resp_idx,
  input logic [DATA_W-1:0] resp_data
);
  localparam logic [IDX_W-1:0] SPECIAL_IDX = '1;

  a_r1_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_lock && !resp_valid));

  a_r2_lock_covers: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_lock);

  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we));

  a_r2_unlock_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready) |=> (!mem_lock && resp_valid));

  a_r5_discard_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_wb_en) |-> (resp_idx != SPECIAL_IDX));

  a_r6_attrs_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_acquire || ord_release || ord_tag_chk) |-> mem_lock);

  a_r7_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (!resp_wb_en && resp_data == '0));

  a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));
endmodule

bind amax_unit amax_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_lock    (mem_lock),
  .ord_acquire (ord_acquire),
  .ord_release (ord_release),
  .ord_tag_chk (ord_tag_chk),
  .resp_valid  (resp_valid),
  .resp_ready  (resp_ready),
  .resp_fault  (resp_fault),
  .resp_wb_en  (resp_wb_en),
  .resp_idx    (resp_idx),
  .resp_data   (resp_data)
);

// File: tb/tb_amax_unit.sv
`timescale 1ns/1ps
module tb_amax_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic        req_wide = 1'b0, req_acq = 1'b0, req_rel = 1'b0;
  logic [63:0] req_operand = '0, req_base_addr = '0;
  logic [4:0]  req_base_idx = '0, req_dst_idx = '0;
  logic        mem_valid, mem_ready = 1'b1, mem_we, mem_wide, mem_lock;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        ord_acquire, ord_release, ord_tag_chk;
  logic        resp_valid, resp_ready = 1'b0, resp_fault, resp_wb_en;
  logic [4:0]  resp_idx;
  logic [63:0] resp_data;

  always #5 clk = ~clk;

  amax_unit dut (.*);

  logic [63:0] mem_word = '0;
  int          n_rd = 0, n_wr = 0;
  logic [63:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
  logic        seen_acq = 0, seen_rel = 0, seen_tag = 0;
  assign mem_rdata = mem_word;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        n_wr       <= n_wr + 1;
        last_waddr <= mem_addr;
        last_wdata <= mem_wdata;
        if (mem_wide) mem_word <= mem_wdata;
        else          mem_word[31:0] <= mem_wdata[31:0];
      end else begin
        n_rd       <= n_rd + 1;
        last_raddr <= mem_addr;
        seen_acq   <= ord_acquire;
        seen_rel   <= ord_release;
        seen_tag   <= ord_tag_chk;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wide, acq, rel;
    logic [4:0]  dst, base;
    logic [63:0] addr, op, memv, exp_w, exp_r;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,5'd3, 5'd2, 64'h1000, 64'h5, 64'h3, 64'h5, 64'h3},
    '{1'b1,1'b1,1'b1,5'd31,5'd31,64'h2000, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 64'h1, 64'h1},
    '{1'b1,1'b0,1'b1,5'd0, 5'd7, 64'h3008, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
      64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF},
    '{1'b0,1'b1,1'b0,5'd31,5'd2, 64'h4004, 64'h0000_0000_8000_0000, 64'hDEAD_BEEF_0000_0001,
      64'h1, 64'h1},
    '{1'b0,1'b1,1'b1,5'd9, 5'd31,64'h5010, 64'hFFFF_FFFF_0000_0010, 64'h1234_5678_FFFF_FFF0,
      64'h10, 64'h0000_0000_FFFF_FFF0},
    '{1'b1,1'b0,1'b0,5'd12,5'd4, 64'h6000, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFFD,
      64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD},
    '{1'b0,1'b0,1'b1,5'd1, 5'd5, 64'h7000, 64'h0000_0000_7FFF_FFFF, 64'h0000_0001_0000_0000,
      64'h7FFF_FFFF, 64'h0}
  };

  int lat;

  // Issue one request; returns after resp_valid is seen (sampled 1 ns after edges).
  task automatic issue(input logic w, input logic a, input logic r, input logic [4:0] d,
                       input logic [4:0] b, input logic [63:0] ad, input logic [63:0] op);
    @(negedge clk);
    req_valid = 1; req_wide = w; req_acq = a; req_rel = r;
    req_dst_idx = d; req_base_idx = b; req_base_addr = ad; req_operand = op;
    @(posedge clk); #1;
    req_valid = 0;
    lat = 0;
    while (!resp_valid) begin @(posedge clk); #1; lat++; end
  endtask

  task automatic release_resp();
    resp_ready = 1;
    @(posedge clk); #1;
    resp_ready = 0;
  endtask

  initial begin
    int rd0, wr0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset req_ready", req_ready, 1);
    chk("R1 reset resp_valid", resp_valid, 0);
    chk("R2 reset mem_lock", {mem_lock, mem_valid}, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      mem_word = VECS[i].memv;
      rd0 = n_rd; wr0 = n_wr;
      issue(VECS[i].wide, VECS[i].acq, VECS[i].rel, VECS[i].dst, VECS[i].base,
            VECS[i].addr, VECS[i].op);
      chk($sformatf("R9 latency v%0d", i), lat, 2);
      chk($sformatf("R4 resp_data v%0d", i), resp_data, VECS[i].exp_r);
      chk($sformatf("R3 write data v%0d", i), last_wdata, VECS[i].exp_w);
      chk($sformatf("R2 read/write count v%0d", i), {n_rd - rd0, n_wr - wr0}, {32'd1, 32'd1});
      chk($sformatf("R2 addresses v%0d", i), {last_raddr == VECS[i].addr, last_waddr == VECS[i].addr}, 2'b11);
      chk($sformatf("R2 unlocked at resp v%0d", i), mem_lock, 0);
      chk($sformatf("R1 busy ready low v%0d", i), req_ready, 0);
      chk($sformatf("R5 wb_en v%0d", i), resp_wb_en, VECS[i].dst != 5'd31);
      chk($sformatf("R5 idx v%0d", i), resp_idx, VECS[i].dst);
      chk($sformatf("R6 acquire v%0d", i), seen_acq, VECS[i].acq && VECS[i].dst != 5'd31);
      chk($sformatf("R6 release v%0d", i), seen_rel, VECS[i].rel);
      chk($sformatf("R8 tag v%0d", i), seen_tag, VECS[i].base != 5'd31);
      chk($sformatf("R7 no fault v%0d", i), resp_fault, 0);
      release_resp();
      chk($sformatf("R1 idle again v%0d", i), req_ready, 1);
    end

    // R7: misaligned stack-pointer base faults with no memory traffic
    mem_word = 64'h55;
    rd0 = n_rd; wr0 = n_wr;
    issue(1'b1, 1'b1, 1'b1, 5'd4, 5'd31, 64'h8008, 64'h99);
    chk("R7 fault flag", resp_fault, 1);
    chk("R7 fault wb_en", resp_wb_en, 0);
    chk("R7 fault data", resp_data, 0);
    chk("R7 no memory access", {n_rd - rd0, n_wr - wr0}, 64'd0);
    chk("R7 memory untouched", mem_word, 64'h55);
    release_resp();

    // R7: same misaligned address through an ordinary base register is not checked
    rd0 = n_rd; wr0 = n_wr;
    issue(1'b1, 1'b0, 1'b0, 5'd4, 5'd6, 64'h8008, 64'h99);
    chk("R7 ordinary base no fault", resp_fault, 0);
    chk("R7 ordinary base accessed", {n_rd - rd0, n_wr - wr0}, {32'd1, 32'd1});
    chk("R3 ordinary base max", mem_word, 64'h99);
    chk("R4 ordinary base old value", resp_data, 64'h55);
    release_resp();

    // R10: memory stall holds the read, lock stays up
    mem_word = 64'h40;
    mem_ready = 0;
    @(negedge clk);
    req_valid = 1; req_wide = 1; req_acq = 0; req_rel = 0;
    req_dst_idx = 5'd2; req_base_idx = 5'd3; req_base_addr = 64'hA000; req_operand = 64'h20;
    @(posedge clk); #1; req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 stalled read held", {mem_valid, mem_we, mem_lock, mem_addr == 64'hA000}, 4'b1011);
    end
    chk("R1 ready low during stall", req_ready, 0);
    mem_ready = 1;
    @(posedge clk); #1;
    chk("R2 write follows read", {mem_valid, mem_we, mem_lock}, 3'b111);
    @(posedge clk); #1;
    chk("R10 resp after stall", resp_valid, 1);
    chk("R3 memory larger kept", last_wdata, 64'h40);

    // R10: response back-pressure
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 resp held", {resp_valid, resp_data == 64'h40}, 2'b11);
      chk("R1 ready low while resp pending", req_ready, 0);
    end
    release_resp();
    chk("R1 ready after resp", req_ready, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule